// File: doc/BRIEF.md
# Oscillator Start-up Delay Sequencer

This block holds the processor core stopped after a reset or a wake-up until the chosen clock source has had time to settle. It reads a 4-bit clock-source code and a 2-bit start-time code, turns them into three cycle budgets, and then counts the pulses that mark each budget. The three budgets are a real-time delay counted on a separate watchdog oscillator, a short fixed run of selected-clock cycles, and a start-up run of selected-clock cycles. When the last budget is used up, `run_en` goes high.

Both counting inputs are single-cycle enable pulses that are synchronous to the system clock, so the whole block runs in one clock domain. A reset runs all three budgets. A wake request while running repeats only the start-up run. A reserved code stops the sequence with an error flag that only a new reset clears. All control and status pins are plain levels or pulses, and no pin has a handshake.

Top module: `osc_startup_seq`

## Requirements
- R1: While `rst_n` is low, `run_en`=0, `busy`=1 and `cfg_err`=0. Driving `rst_n` low clears `run_en` at once, without waiting for a clock edge, in every phase.
- R2: The first rising edge after `rst_n` goes high is a load cycle. The fuse codes are captured on that edge, any `osc_tick` or `wdt_tick` present on that edge is not counted, and later changes to the fuse codes have no effect until the next reset.
- R3: A reset sequence counts `wdt_tick` pulses for the real-time budget, then `osc_tick` pulses for the fixed budget, then `osc_tick` pulses for the start-up budget. A budget of zero is skipped. A pulse counts only toward the phase in progress when it is sampled. `run_en` is high and `busy` is low from the clock edge that samples the final start-up pulse, and they stay that way until a wake request or a reset. `run_en` is low before that edge.
- R4: For `clk_sel` 0000, 0010 and 0100, the start-up budget is 6 and the fixed budget is 14. The real-time budget is 0 for `start_sel`=00, 512 for 01 and 8192 for 10.
- R5: For `clk_sel` 1000 to 1111, the key is {`clk_sel[0]`,`start_sel`}. The start-up budget is 258 for keys 000 and 001, 1024 for 010, 011 and 100, and 16384 for 101, 110 and 111. The real-time budget is 512 for 000, 011 and 110, 8192 for 001, 100 and 111, and 0 for 010 and 101. The fixed budget is 14.
- R6: For `clk_sel` 0110, the fixed budget is 0. `start_sel` 00 gives a start-up budget of 1024 and a real-time budget of 512. 01 gives 1024 and 8192. 10 gives 32768 and 8192.
- R7: The codes `clk_sel` 0001, 0011, 0101 and 0111 are reserved, and so is `start_sel`=11 with `clk_sel` 0000, 0010, 0100 or 0110. After the load edge, a reserved code sets `cfg_err`=1 with `run_en`=0 and `busy`=0. This holds, whatever the ticks and wake requests do, until the next reset.
- R8: A `wake_req` sampled while `run_en` is high makes `run_en`=0 and `busy`=1 from that edge. The block then counts only the latched start-up budget of `osc_tick` pulses and raises `run_en` again on the edge that samples the last one. Ticks on the wake edge itself are not counted.
- R9: A `wake_req` sampled while `busy` or `cfg_err` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts a reset sequence |
| osc_tick | input | 1 | One-cycle pulse per cycle of the selected oscillator |
| wdt_tick | input | 1 | One-cycle pulse per cycle of the watchdog oscillator |
| wake_req | input | 1 | One-cycle request to leave power-down |
| clk_sel | input | 4 | Clock-source code |
| start_sel | input | 2 | Start-time code |
| run_en | output | 1 | High when the core may execute |
| busy | output | 1 | High while a delay sequence is in progress |
| cfg_err | output | 1 | High after a reserved code was loaded |

## Verification
The hardest case to reach is a phase boundary where the final pulse of one budget arrives together with a pulse of the other source, or with a stray wake request. Only exact per-phase counting gets the release cycle right there. The stimulus drives both tick inputs and occasional wake requests from random streams of varying density throughout every phase. The bench counts only the pulses that belong to the current phase and requires `run_en` to rise on exactly the edge that samples the last one. Long budgets (16384 and 32768 cycles) are run as directed cases at high tick density, so the run stays short.

// File: rtl/osc_startup_pkg.sv
package osc_startup_pkg;

  typedef enum logic [2:0] {
    PH_LOAD = 3'd0,
    PH_RTD  = 3'd1,
    PH_FIX  = 3'd2,
    PH_SU   = 3'd3,
    PH_RUN  = 3'd4,
    PH_ERR  = 3'd5
  } phase_e;

  function automatic int cnt_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/osc_fuse_decode.sv
module osc_fuse_decode #(
  parameter int CW         = 16,
  parameter int RTD_SHORT  = 512,
  parameter int RTD_LONG   = 8192,
  parameter int FIX_CYC    = 14,
  parameter int SU_TINY    = 6,
  parameter int SU_RESON   = 258,
  parameter int SU_MID     = 1024,
  parameter int SU_XTAL    = 16384,
  parameter int SU_LFXTAL  = 32768
) (
  input  logic [3:0]    clk_sel,
  input  logic [1:0]    start_sel,
  output logic [CW-1:0] rtd_n,
  output logic [CW-1:0] fix_n,
  output logic [CW-1:0] su_n,
  output logic          reserved
);

  localparam logic [CW-1:0] C_RS  = CW'(RTD_SHORT);
  localparam logic [CW-1:0] C_RL  = CW'(RTD_LONG);
  localparam logic [CW-1:0] C_FX  = CW'(FIX_CYC);
  localparam logic [CW-1:0] C_ST  = CW'(SU_TINY);
  localparam logic [CW-1:0] C_SR  = CW'(SU_RESON);
  localparam logic [CW-1:0] C_SM  = CW'(SU_MID);
  localparam logic [CW-1:0] C_SX  = CW'(SU_XTAL);
  localparam logic [CW-1:0] C_SL  = CW'(SU_LFXTAL);

  logic [2:0] xkey;
  assign xkey = {clk_sel[0], start_sel};

  always_comb begin
    rtd_n    = '0;
    fix_n    = C_FX;
    su_n     = C_ST;
    reserved = 1'b0;
    if (clk_sel[3]) begin
      // resonator / crystal family
      case (xkey)
        3'b000, 3'b001:         su_n = C_SR;
        3'b010, 3'b011, 3'b100: su_n = C_SM;
        default:                su_n = C_SX;
      endcase
      case (xkey)
        3'b000, 3'b011, 3'b110: rtd_n = C_RS;
        3'b001, 3'b100, 3'b111: rtd_n = C_RL;
        default:                rtd_n = '0;
      endcase
    end else if (clk_sel[0]) begin
      reserved = 1'b1;
    end else if (clk_sel[2:1] == 2'b11) begin
      // low-frequency crystal
      fix_n = '0;
      case (start_sel)
        2'b00:   begin su_n = C_SM; rtd_n = C_RS; end
        2'b01:   begin su_n = C_SM; rtd_n = C_RL; end
        2'b10:   begin su_n = C_SL; rtd_n = C_RL; end
        default: reserved = 1'b1;
      endcase
    end else begin
      // external, internal RC, watchdog oscillator
      case (start_sel)
        2'b00:   rtd_n = '0;
        2'b01:   rtd_n = C_RS;
        2'b10:   rtd_n = C_RL;
        default: reserved = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/osc_phase_counter.sv
module osc_phase_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] target,
  output logic          last
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (tick)   cnt <= cnt + CW'(1);
  end

  assign last = tick && (target != '0) && (cnt == target - CW'(1));

  AST_CNT_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (target != '0) |-> (cnt < target)) else $error("count passed budget"); // R3

endmodule

// File: rtl/osc_startup_seq.sv
module osc_startup_seq #(
  parameter int RTD_SHORT  = 512,
  parameter int RTD_LONG   = 8192,
  parameter int FIX_CYC    = 14,
  parameter int SU_TINY    = 6,
  parameter int SU_RESON   = 258,
  parameter int SU_MID     = 1024,
  parameter int SU_XTAL    = 16384,
  parameter int SU_LFXTAL  = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       wdt_tick,
  input  logic       wake_req,
  input  logic [3:0] clk_sel,
  input  logic [1:0] start_sel,
  output logic       run_en,
  output logic       busy,
  output logic       cfg_err
);
  import osc_startup_pkg::*;

  localparam int CW = cnt_width(cnt_width(SU_LFXTAL, SU_XTAL) > cnt_width(RTD_LONG, FIX_CYC)
                                  ? SU_LFXTAL : RTD_LONG,
                                SU_XTAL > RTD_LONG ? SU_XTAL : RTD_LONG);

  phase_e        ph, nxt;
  logic [CW-1:0] rtd_d, fix_d, su_d;
  logic [CW-1:0] rtd_q, fix_q, su_q;
  logic          rsv_d;
  logic [CW-1:0] tgt;
  logic          cnt_tick, cnt_last, cnt_clr;

  osc_fuse_decode #(
    .CW(CW), .RTD_SHORT(RTD_SHORT), .RTD_LONG(RTD_LONG), .FIX_CYC(FIX_CYC),
    .SU_TINY(SU_TINY), .SU_RESON(SU_RESON), .SU_MID(SU_MID),
    .SU_XTAL(SU_XTAL), .SU_LFXTAL(SU_LFXTAL)
  ) u_dec (
    .clk_sel  (clk_sel),
    .start_sel(start_sel),
    .rtd_n    (rtd_d),
    .fix_n    (fix_d),
    .su_n     (su_d),
    .reserved (rsv_d)
  );

  always_comb begin
    nxt = ph;
    case (ph)
      PH_LOAD: begin
        if (rsv_d)              nxt = PH_ERR;
        else if (rtd_d != '0)   nxt = PH_RTD;
        else if (fix_d != '0)   nxt = PH_FIX;
        else                    nxt = PH_SU;
      end
      PH_RTD:  if (cnt_last) nxt = (fix_q != '0) ? PH_FIX : PH_SU;
      PH_FIX:  if (cnt_last) nxt = PH_SU;
      PH_SU:   if (cnt_last) nxt = PH_RUN;
      PH_RUN:  if (wake_req) nxt = PH_SU;
      default: nxt = PH_ERR;
    endcase
  end

  always_comb begin
    case (ph)
      PH_RTD:  begin tgt = rtd_q; cnt_tick = wdt_tick; end
      PH_FIX:  begin tgt = fix_q; cnt_tick = osc_tick; end
      PH_SU:   begin tgt = su_q;  cnt_tick = osc_tick; end
      default: begin tgt = '0;    cnt_tick = 1'b0;     end
    endcase
  end

  assign cnt_clr = (nxt != ph);

  osc_phase_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .tick  (cnt_tick),
    .target(tgt),
    .last  (cnt_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_LOAD;
      rtd_q <= '0;
      fix_q <= '0;
      su_q  <= '0;
    end else begin
      ph <= nxt;
      if (ph == PH_LOAD) begin
        rtd_q <= rtd_d;
        fix_q <= fix_d;
        su_q  <= su_d;
      end
    end
  end

  assign run_en  = (ph == PH_RUN);
  assign cfg_err = (ph == PH_ERR);
  assign busy    = (ph == PH_LOAD) || (ph == PH_RTD) || (ph == PH_FIX) || (ph == PH_SU);

  AST_RUN_AFTER_OSC_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> $past(osc_tick)) else $error("run without final tick"); // R3

  AST_WAKE_DROPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && wake_req) |=> (!run_en && busy)) else $error("wake ignored"); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> (cfg_err && !run_en)) else $error("error cleared"); // R7

  AST_BUSY_NO_WAKE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cnt_last && wake_req) |=> busy) else $error("wake left busy"); // R9

endmodule

// File: tb/osc_startup_seq_tb.sv
module osc_startup_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic       wdt_tick = 1'b0;
  logic       wake_req = 1'b0;
  logic [3:0] clk_sel = 4'b0010;
  logic [1:0] start_sel = 2'b10;
  logic       run_en, busy, cfg_err;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  osc_startup_seq u_dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .wdt_tick(wdt_tick),
    .wake_req(wake_req), .clk_sel(clk_sel), .start_sel(start_sel),
    .run_en(run_en), .busy(busy), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected budgets per R4/R5/R6/R7
  function automatic void exp_cfg(input logic [3:0] cs, input logic [1:0] st,
                                  output int rtd, output int fix, output int su, output bit rsv);
    logic [2:0] k;
    rtd = 0; fix = 14; su = 6; rsv = 1'b0;
    k = {cs[0], st};
    if (cs[3]) begin
      su  = (k <= 3'd1) ? 258 : (k <= 3'd4) ? 1024 : 16384;
      rtd = (k == 3'd2 || k == 3'd5) ? 0 : (k == 3'd0 || k == 3'd3 || k == 3'd6) ? 512 : 8192;
    end else if (cs[0] || st == 2'b11) begin
      rsv = 1'b1;
    end else if (cs == 4'b0110) begin
      fix = 0;
      su  = (st == 2'b10) ? 32768 : 1024;
      rtd = (st == 2'b00) ? 512 : 8192;
    end else begin
      rtd = (st == 2'b00) ? 0 : (st == 2'b01) ? 512 : 8192;
    end
  endfunction

  task automatic do_reset(input logic [3:0] cs, input logic [1:0] st);
    @(negedge clk);
    rst_n = 1'b0; clk_sel = cs; start_sel = st;
    #1;
    chk(run_en == 0 && busy == 1 && cfg_err == 0, "R1 reset state", {run_en, busy, cfg_err}, 3'b010);
    repeat (2) @(negedge clk);
    rst_n = 1'b1; osc_tick = 1'b1; wdt_tick = 1'b1; wake_req = 1'b0; // R2: ignored ticks
    @(negedge clk);
    clk_sel = ~cs; start_sel = ~st; // R2: later fuse changes have no effect
  endtask

  task automatic run_phase(input int n, input bit use_wdt, input bit fin, input int pct,
                           inout int early);
    int left = n;
    while (left > 0) begin
      osc_tick = (($urandom % 100) < pct);
      wdt_tick = (($urandom % 100) < pct);
      wake_req = (($urandom % 8) == 0); // R9: requests while busy
      if (use_wdt ? wdt_tick : osc_tick) left--;
      @(negedge clk);
      if (run_en && !(fin && left == 0)) early++;
      if (!run_en && !busy) early++;
    end
    osc_tick = 1'b0; wdt_tick = 1'b0; wake_req = 1'b0;
  endtask

  task automatic full_seq(input logic [3:0] cs, input logic [1:0] st, input int pct, input string req);
    int rtd, fix, su, early;
    bit rsv;
    exp_cfg(cs, st, rtd, fix, su, rsv);
    do_reset(cs, st);
    if (rsv) begin
      chk(cfg_err == 1 && run_en == 0 && busy == 0, "R7 reserved code", {run_en, busy, cfg_err}, 3'b001);
      for (int i = 0; i < 40; i++) begin
        osc_tick = $urandom % 2; wdt_tick = $urandom % 2; wake_req = $urandom % 2;
        @(negedge clk);
      end
      osc_tick = 0; wdt_tick = 0; wake_req = 0;
      chk(cfg_err == 1 && run_en == 0 && busy == 0, "R7 R9 error held", {run_en, busy, cfg_err}, 3'b001);
    end else begin
      early = 0;
      if (rtd > 0) run_phase(rtd, 1'b1, 1'b0, pct, early);
      if (fix > 0) run_phase(fix, 1'b0, 1'b0, pct, early);
      run_phase(su, 1'b0, 1'b1, pct, early);
      chk(early == 0, {req, " R3 R9 held until last tick"}, early, 0);
      chk(run_en == 1 && busy == 0 && cfg_err == 0, {req, " R2 R3 release edge"},
          {run_en, busy, cfg_err}, 3'b100);
    end
  endtask

  task automatic wake_seq(input int su, input int pct);
    int early = 0;
    @(negedge clk);
    wake_req = 1'b1; osc_tick = 1'b1; wdt_tick = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    chk(run_en == 0 && busy == 1, "R8 wake drops run", {run_en, busy}, 2'b01);
    run_phase(su, 1'b0, 1'b1, pct, early);
    chk(early == 0, "R8 R9 wake budget", early, 0);
    chk(run_en == 1 && busy == 0, "R8 wake release", {run_en, busy}, 2'b10);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int rtd, fix, su;
    bit rsv;
    logic [3:0] cs;
    logic [1:0] st;
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk);
    #1;
    chk(run_en == 0 && busy == 1 && cfg_err == 0, "R1 power-up reset", {run_en, busy, cfg_err}, 3'b010);

    // R4 directed
    full_seq(4'b0000, 2'b00, 70, "R4 ext 00");
    full_seq(4'b0100, 2'b00, 100, "R4 wdosc 00");
    full_seq(4'b0010, 2'b01, 80, "R4 rc 01");
    wake_seq(6, 60);
    full_seq(4'b0010, 2'b10, 100, "R4 rc 10");
    // R1: reset in RUN clears run_en at once
    @(negedge clk); rst_n = 1'b0; #1;
    chk(run_en == 0, "R1 async clear in run", run_en, 0);
    // R5 directed
    full_seq(4'b1010, 2'b00, 75, "R5 key 000");
    full_seq(4'b1011, 2'b01, 95, "R5 key 101");
    wake_seq(16384, 95);
    // R6 directed
    full_seq(4'b0110, 2'b00, 70, "R6 lf 00");
    full_seq(4'b0110, 2'b10, 100, "R6 lf 10");
    // R7 directed
    full_seq(4'b0011, 2'b00, 50, "R7 0011");
    full_seq(4'b0010, 2'b11, 50, "R7 rc 11");
    full_seq(4'b0110, 2'b11, 50, "R7 lf 11");
    // R1: reset in the middle of a phase
    do_reset(4'b0010, 2'b01);
    for (int i = 0; i < 30; i++) begin
      wdt_tick = 1'b1; @(negedge clk);
    end
    rst_n = 1'b0; #1;
    chk(run_en == 0 && busy == 1, "R1 reset mid phase", {run_en, busy}, 2'b01);
    // random mix
    for (int it = 0; it < 20; it++) begin
      do begin
        cs = 4'($urandom); st = 2'($urandom);
        exp_cfg(cs, st, rtd, fix, su, rsv);
      end while (!rsv && (rtd + fix + su) > 1100);
      full_seq(cs, st, 60 + ($urandom % 41), "R3 R4 R5 R6 R7 random");
      if (!rsv && ($urandom % 2)) wake_seq(su, 50 + ($urandom % 51));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule